// File: doc/BRIEF.md
# Lane Group Reset Sequencer

This block walks one group of eight lanes of a sixteen-lane PHY control block through a fixed reset procedure. A single start pulse, together with a group select, launches it. First the selected lanes are taken out of the run vector. The sequencer then waits until those lanes stop reporting busy. Next it pulses the receive and transmit I/O-reset vectors, and after that pulses each lane's phase-rotator reset, one lane at a time. At the end it rewrites each lane's mode fields and clears that lane's power-down bits.

The shared vectors use reversed bit numbering: lane 0 sits at bit 15 and lane 15 at bit 0. The per-lane configuration words are kept in natural lane order. Unselected lanes are never touched. A one-cycle done pulse marks the end of the sequence.

Top module: `lane_rst_seq`

## Requirements
- R1: The group select maps to a vector mask as follows. Group 0 (lanes 0..7) is bits 15..8 of the shared vectors, mask 0xFF00. Group 1 (lanes 8..15) is bits 7..0, mask 0x00FF.
- R2: The run vector resets to 0xFFFF. One cycle after a start is accepted, the run vector has the mask bits cleared and every other bit unchanged.
- R3: After clearing the run bits, the sequencer holds until (busy & mask) == 0. Busy bits outside the mask have no effect.
- R4: The I/O-reset steps then take one cycle each, in this order: receive vector set, transmit vector set, receive vector clear, transmit vector clear. Only the mask bits change.
- R5: Each per-lane word has bit 0 as the phase-rotator reset. The selected lanes are visited from the lowest lane number to the highest. Each lane's bit is 1 for exactly one cycle and then returns to 0, and at most one lane has it set at any time.
- R6: Each lane word is 11 bits, and lane l occupies lane_cfg_o[l*11 +: 11]. Bits 4:1 are the phase step, bits 7:5 the IQ resolution, and bits 8, 9 and 10 are the transmit, receive-analog and receive-digital power-down bits. The reset value is 0x700. In the restore step each selected lane, lowest first and one per cycle, is rewritten as (old & ~0x7FE) | 0x0F0. With bit 0 at 0 this gives 0x0F0.
- R7: A start that arrives while a sequence is running is ignored, along with its group select.
- R8: done_o is 1 for exactly one cycle, in the cycle after the last lane's restore write. It is 0 at all other times.
- R9: Under reset the outputs are: run vector 0xFFFF, both I/O-reset vectors 0, every lane word 0x700, and done 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| grp_i | input | 1 | Lane group select (0: lanes 0..7, 1: lanes 8..15) |
| busy_i | input | 16 | Per-lane busy vector, reversed bit order |
| run_o | output | 16 | Run-lane vector, reversed bit order |
| rx_iorst_o | output | 16 | Receive I/O-reset vector, reversed bit order |
| tx_iorst_o | output | 16 | Transmit I/O-reset vector, reversed bit order |
| lane_cfg_o | output | 176 | Per-lane configuration words, natural lane order |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench holds the selected busy bits high for several cycles. A design that skipped the wait, or that tested the wrong half of the busy vector, would move on to the I/O-reset steps too early. It also keeps busy asserted only on unselected lanes; a design that failed to mask the busy vector would then stall forever. Both groups are run, so a mask built without the bit reversal would clear the wrong half of the run vector and reconfigure the wrong lanes. A second start issued mid-sequence with the other group selected would, if accepted, restart the sequence or switch the group and corrupt the reference comparison.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  // per-lane configuration word layout
  localparam int CFGW      = 11;
  localparam int PR_BIT    = 0;
  localparam logic [CFGW-1:0] CFG_RST   = 11'h700;
  localparam logic [CFGW-1:0] REST_DATA = 11'h0F0;
  localparam logic [CFGW-1:0] REST_MASK = 11'h7FE;

  typedef logic [CFGW-1:0] cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RUNCLR, S_WAIT, S_RXSET, S_TXSET,
    S_RXCLR, S_TXCLR, S_PRSET, S_PRCLR, S_REST
  } seq_st_t;

  function automatic cfg_t cfg_rmw(cfg_t old, cfg_t data, cfg_t fmask);
    return (old & ~fmask) | data;
  endfunction
endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int NLANE = 16,
  parameter int GRPW  = 8,
  localparam int NGRP = NLANE / GRPW,
  localparam int GSW  = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int LIW  = $clog2(NLANE),
  localparam int CW   = (GRPW > 1) ? $clog2(GRPW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [GSW-1:0]   grp_i,
  input  logic [NLANE-1:0] busy_i,
  output seq_st_t          st_o,
  output logic [NLANE-1:0] mask_o,
  output logic [LIW-1:0]   lane_o,
  output logic             done_o
);
  // natural selection shifted to the group, complemented into register order
  function automatic logic [NLANE-1:0] reg_mask(logic [GSW-1:0] g);
    logic [NLANE-1:0] sel;
    sel = {{(NLANE-GRPW){1'b0}}, {GRPW{1'b1}}} << (int'(g) * GRPW);
    return ~sel;
  endfunction

  seq_st_t          st;
  logic [NLANE-1:0] mask_q;
  logic [GSW-1:0]   grp_q;
  logic [CW-1:0]    cnt;
  logic             done_q;
  logic             last_lane;

  assign last_lane = (int'(cnt) == GRPW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mask_q <= '0;
      grp_q  <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          mask_q <= reg_mask(grp_i);
          grp_q  <= grp_i;
          cnt    <= '0;
          st     <= S_RUNCLR;
        end
        S_RUNCLR: st <= S_WAIT;
        S_WAIT:   if ((busy_i & mask_q) == '0) st <= S_RXSET;
        S_RXSET:  st <= S_TXSET;
        S_TXSET:  st <= S_RXCLR;
        S_RXCLR:  st <= S_TXCLR;
        S_TXCLR:  st <= S_PRSET;
        S_PRSET:  st <= S_PRCLR;
        S_PRCLR: begin
          if (last_lane) begin
            cnt <= '0;
            st  <= S_REST;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= S_PRSET;
          end
        end
        S_REST: begin
          if (last_lane) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign st_o   = st;
  assign mask_o = mask_q;
  assign lane_o = LIW'(int'(grp_q) * GRPW + int'(cnt));
  assign done_o = done_q;
endmodule

// File: rtl/lrs_vec.sv
module lrs_vec
  import lrs_pkg::*;
#(
  parameter int NLANE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_st_t          st_i,
  input  logic [NLANE-1:0] mask_i,
  output logic [NLANE-1:0] run_o,
  output logic [NLANE-1:0] rxr_o,
  output logic [NLANE-1:0] txr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o <= '1;
      rxr_o <= '0;
      txr_o <= '0;
    end else begin
      case (st_i)
        S_RUNCLR: run_o <= run_o & ~mask_i;
        S_RXSET:  rxr_o <= rxr_o | mask_i;
        S_TXSET:  txr_o <= txr_o | mask_i;
        S_RXCLR:  rxr_o <= rxr_o & ~mask_i;
        S_TXCLR:  txr_o <= txr_o & ~mask_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lrs_bank.sv
module lrs_bank
  import lrs_pkg::*;
#(
  parameter int NLANE = 16,
  localparam int LIW  = $clog2(NLANE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  seq_st_t               st_i,
  input  logic [LIW-1:0]        lane_i,
  output logic [NLANE*CFGW-1:0] cfg_o
);
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    cfg_t r;
    logic hit;
    assign hit = (lane_i == LIW'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= CFG_RST;
      end else if (hit) begin
        case (st_i)
          S_PRSET: r[PR_BIT] <= 1'b1;
          S_PRCLR: r[PR_BIT] <= 1'b0;
          S_REST:  r <= cfg_rmw(r, REST_DATA, REST_MASK);
          default: ;
        endcase
      end
    end
    assign cfg_o[l*CFGW +: CFGW] = r;
  end
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
  import lrs_pkg::*;
#(
  parameter int NLANE = 16,
  parameter int GRPW  = 8,
  localparam int NGRP = NLANE / GRPW,
  localparam int GSW  = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int LIW  = $clog2(NLANE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [GSW-1:0]        grp_i,
  input  logic [NLANE-1:0]      busy_i,
  output logic [NLANE-1:0]      run_o,
  output logic [NLANE-1:0]      rx_iorst_o,
  output logic [NLANE-1:0]      tx_iorst_o,
  output logic [NLANE*CFGW-1:0] lane_cfg_o,
  output logic                  done_o
);
  seq_st_t          seq_st;
  logic [NLANE-1:0] seq_mask;
  logic [LIW-1:0]   seq_lane;
  logic             seq_active;

  assign seq_active = (seq_st != S_IDLE);

  lrs_ctrl #(.NLANE(NLANE), .GRPW(GRPW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .grp_i(grp_i),
    .busy_i(busy_i), .st_o(seq_st), .mask_o(seq_mask),
    .lane_o(seq_lane), .done_o(done_o)
  );

  lrs_vec #(.NLANE(NLANE)) u_vec (
    .clk(clk), .rst_n(rst_n), .st_i(seq_st), .mask_i(seq_mask),
    .run_o(run_o), .rxr_o(rx_iorst_o), .txr_o(tx_iorst_o)
  );

  lrs_bank #(.NLANE(NLANE)) u_bank (
    .clk(clk), .rst_n(rst_n), .st_i(seq_st), .lane_i(seq_lane),
    .cfg_o(lane_cfg_o)
  );
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk
  import lrs_pkg::*;
#(
  parameter int NLANE = 16,
  parameter int GRPW  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic [NLANE-1:0]      busy_i,
  input logic [NLANE-1:0]      run_o,
  input logic [NLANE-1:0]      rx_iorst_o,
  input logic [NLANE-1:0]      tx_iorst_o,
  input logic [NLANE*CFGW-1:0] lane_cfg_o,
  input logic                  done_o,
  input seq_st_t               seq_st,
  input logic [NLANE-1:0]      seq_mask,
  input logic                  seq_active
);
  logic [NLANE-1:0] pr_bits;
  for (genvar l = 0; l < NLANE; l++) begin : g_pr
    assign pr_bits[l] = lane_cfg_o[l*CFGW + PR_BIT];
  end

  // R1
  p_mask_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |-> ($countones(seq_mask) == GRPW));
  // R2
  p_run_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_active |=> ((run_o & ~$past(seq_mask)) == ($past(run_o) & ~$past(seq_mask))));
  // R3
  p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == S_WAIT && (busy_i & seq_mask) != '0) |=> (seq_st == S_WAIT));
  // R4
  p_rx_before_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|tx_iorst_o) |-> ((rx_iorst_o & seq_mask) == seq_mask));
  // R5
  p_one_pr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pr_bits));
  // R7
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && start_i) |=> $stable(seq_mask));
  // R8
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind lane_rst_seq lrs_chk #(.NLANE(NLANE), .GRPW(GRPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
  .run_o(run_o), .rx_iorst_o(rx_iorst_o), .tx_iorst_o(tx_iorst_o),
  .lane_cfg_o(lane_cfg_o), .done_o(done_o), .seq_st(seq_st),
  .seq_mask(seq_mask), .seq_active(seq_active)
);

// File: tb/sim_lane_rst_seq.sv
module sim_lane_rst_seq;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [0:0]   grp_i;
  logic [15:0]  busy_i;
  logic [15:0]  run_o, rx_iorst_o, tx_iorst_o;
  logic [175:0] lane_cfg_o;
  logic         done_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  lane_rst_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .grp_i(grp_i),
    .busy_i(busy_i), .run_o(run_o), .rx_iorst_o(rx_iorst_o),
    .tx_iorst_o(tx_iorst_o), .lane_cfg_o(lane_cfg_o), .done_o(done_o)
  );

  // behavioural reference model
  logic [15:0] m_run = 16'hFFFF, m_rx = 16'h0, m_tx = 16'h0, m_mask = 16'h0;
  logic [10:0] m_cfg [16];
  logic        m_done = 1'b0;
  int          ph = 0, k = 0, base = 0;

  initial for (int l = 0; l < 16; l++) m_cfg[l] = 11'h700;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 16'hFFFF; m_rx = 0; m_tx = 0; m_done = 0; ph = 0; k = 0;
      for (int l = 0; l < 16; l++) m_cfg[l] = 11'h700;
    end else begin
      m_done = 0;
      case (ph)
        0: if (start_i) begin // R7: only honoured here
             base = grp_i ? 8 : 0;
             m_mask = 0;
             for (int l = 0; l < 8; l++) m_mask[15 - (base + l)] = 1'b1; // R1 reversal
             ph = 1;
           end
        1: begin m_run = m_run & ~m_mask; ph = 2; end
        2: if ((busy_i & m_mask) == 0) ph = 3;
        3: begin m_rx = m_rx | m_mask;  ph = 4; end
        4: begin m_tx = m_tx | m_mask;  ph = 5; end
        5: begin m_rx = m_rx & ~m_mask; ph = 6; end
        6: begin m_tx = m_tx & ~m_mask; ph = 7; k = 0; end
        7: begin m_cfg[base+k][0] = 1'b1; ph = 8; end
        8: begin
             m_cfg[base+k][0] = 1'b0;
             if (k == 7) begin k = 0; ph = 9; end else begin k++; ph = 7; end
           end
        9: begin
             m_cfg[base+k] = {3'b000, 3'b111, 4'b1000, m_cfg[base+k][0]};
             if (k == 7) begin ph = 0; m_done = 1; end else k++;
           end
        default: ph = 0;
      endcase
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    cmp("R1/R2 run", 32'(run_o), 32'(m_run));
    cmp("R3/R4 rx_iorst", 32'(rx_iorst_o), 32'(m_rx));
    cmp("R4 tx_iorst", 32'(tx_iorst_o), 32'(m_tx));
    for (int l = 0; l < 16; l++) begin
      cmp("R5 pr_rst", 32'(lane_cfg_o[l*11]), 32'(m_cfg[l][0]));
      cmp("R6 lane_cfg", 32'(lane_cfg_o[l*11 +: 11]), 32'(m_cfg[l]));
    end
    cmp("R7/R8 done", 32'(done_o), 32'(m_done));
  end

  task automatic wait_done();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  task automatic launch(logic g, logic [15:0] bsy, int hold, logic [15:0] bg);
    @(negedge clk);
    start_i = 1'b1; grp_i = g; busy_i = bsy;
    @(negedge clk);
    start_i = 1'b0;
    repeat (hold) @(negedge clk);
    busy_i = bg;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; grp_i = 1'b0; busy_i = 16'h0;
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp("R9 run reset", 32'(run_o), 32'hFFFF);
    cmp("R9 cfg reset", 32'(lane_cfg_o[0 +: 11]), 32'h700);
    cmp("R9 done reset", 32'(done_o), 32'h0);
    rst_n = 1'b1;
    // R3: selected lanes busy for a while (group 0 -> bits 15:8)
    launch(1'b0, 16'hFF00, 6, 16'h0000);
    wait_done();
    // R3: busy only on unselected bits must not stall group 1
    launch(1'b1, 16'hFF00, 0, 16'hFF00);
    wait_done();
    busy_i = 16'h0;
    // R7: second start mid-sequence with the other group
    launch(1'b1, 16'h0000, 4, 16'h0000);
    start_i = 1'b1; grp_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    // single stuck busy bit on lane 7 (bit 8)
    launch(1'b0, 16'h0100, 20, 16'h0000);
    wait_done();
    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule